// File: doc/BRIEF.md
# Interleaved ADC Mismatch Calibrator

This block sits on the output of a four-way time-interleaved converter. Each core supplies every fourth sample, and the samples arrive one per clock in a fixed round-robin order. Because the cores never match exactly, the combined stream carries a repeating offset pattern and an amplitude modulation at one quarter of the sample rate. The block removes both while data flows. For each core it keeps a leaky average of that core's samples and subtracts it. For each core it also keeps a leaky average of the magnitude of the offset-corrected samples, and it moves a per-core gain word one step at a time so that each core's magnitude matches the mean over all cores.

The estimators keep running in the background, so the corrections follow slow drift. A freeze input holds the estimates at their current values while they are still applied. Dropping the enable input bypasses the correction and passes samples through unchanged. A read-select port returns the offset and gain words of any one core at any time.

Top module: `ilv_mismatch_cal`

## Requirements
- R1: A 2-bit core counter starts at 0 after reset and steps by one, modulo 4, on every cycle with in_vld high, whatever the state of en and freeze. On cycles without a valid input it holds. The sample accepted while the counter reads i belongs to core i.
- R2: out_vld repeats in_vld exactly 3 cycles later. Outputs leave in the order the inputs arrived, and out_vld is low after reset.
- R3: With en high, the output is ((x - off[i]) * g[i]) >>> 14, saturated to 16 bits. Here x is the signed input, off[i] is the signed 16-bit offset word of the sample's core, and g[i] is its unsigned Q2.14 gain word, both taken as they stood before this sample's own update.
- R4: A corrected result above 32767 comes out as 32767, and one below -32768 comes out as -32768.
- R5: Each core has an offset accumulator A with 16 fraction bits. When a sample is used for estimation, A of that core only becomes A + (((x << 16) - A) >>> K), and the offset word is A >>> 16.
- R6: Each core has a magnitude accumulator M. It takes the same step as R5, using |x - off[i]| as its input. On the same update, the core's gain word rises by 1 if g[i] * (M[i] >>> 16) < avg << 14 and falls by 1 if it is greater. avg is the floor of the mean of (M >>> 16) over the four cores, and all of these values are from before the update. The gain word stays within 0 to 65535.
- R7: The leak shift K is the k_shift input clamped to the range 8 to 16.
- R8: While freeze is high, no offset, magnitude or gain word changes, but the corrections are still applied to the data.
- R9: While en is low, out_dat equals the input sample unchanged and no estimator state changes.
- R10: After reset, every offset word is 0 and every gain word is 16384. rd_offset and rd_gain show the words of the core selected by rd_core in the same cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Correction and estimation enable |
| freeze | input | 1 | Holds all estimates, corrections still applied |
| k_shift | input | 5 | Leak shift for the running averages, clamped to 8..16 |
| in_vld | input | 1 | Input sample valid |
| in_dat | input | 16 | Input sample, signed two's complement |
| out_vld | output | 1 | Output sample valid |
| out_dat | output | 16 | Corrected sample, signed two's complement |
| rd_core | input | 2 | Core selected for readback |
| rd_offset | output | 16 | Offset word of the selected core, signed |
| rd_gain | output | 16 | Gain word of the selected core, Q2.14 |

## Verification
The bench gives each core its own bias and its own amplitude on top of random values, with random gaps in the valid stream. Any sample sent to the wrong core, or any correction drawn from a neighbouring core, then shows up as a wrong output or a wrong readback word. A bypass burst shows pass-through apart from correction, and a frozen burst shows that the corrections are still applied while the readback stays fixed. Runs with the leak shift set below and above its range separate the clamp from the raw value. Large opposite biases on two cores, followed by full-scale samples of the other sign, drive the result into both saturation limits.

// File: rtl/ilv_cal_pkg.sv
package ilv_cal_pkg;
  localparam int SW    = 16;          // sample width
  localparam int FR    = 16;          // accumulator fraction bits
  localparam int AW    = SW + FR + 2; // accumulator width
  localparam int GW    = 16;          // gain word width
  localparam int GF    = 14;          // gain fraction bits
  localparam int PW    = 2 * SW + 2;  // product width
  localparam int KW    = 5;
  localparam int KMIN  = 8;
  localparam int KMAX  = 16;
  localparam logic [GW-1:0] GAIN_ONE = GW'(1 << GF);

  typedef logic signed [SW-1:0] samp_t;
  typedef logic signed [AW-1:0] acc_t;
  typedef logic [GW-1:0]        gain_t;

  function automatic logic [KW-1:0] clamp_k(input logic [KW-1:0] k);
    if (k < KW'(KMIN)) return KW'(KMIN);
    if (k > KW'(KMAX)) return KW'(KMAX);
    return k;
  endfunction

  // one leaky-average step toward v (v in integer units)
  function automatic acc_t leaky_step(input acc_t acc, input logic signed [SW:0] v,
                                      input logic [KW-1:0] k);
    acc_t tgt;
    tgt = acc_t'(v) <<< FR;
    return acc + ((tgt - acc) >>> k);
  endfunction

  // one-LSB gain nudge toward avg / m
  function automatic gain_t gain_step(input gain_t g, input logic [SW-1:0] m,
                                      input logic [SW-1:0] avg);
    logic [2*SW-1:0] lhs;
    logic [2*SW-1:0] rhs;
    lhs = g * m;
    rhs = (2*SW)'(avg) << GF;
    if (lhs < rhs && g != '1) return g + 1'b1;
    if (lhs > rhs && g != '0) return g - 1'b1;
    return g;
  endfunction

  function automatic samp_t shift_sat(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] s;
    s = p >>> GF;
    if (&s[PW-1:SW-1] || ~|s[PW-1:SW-1]) return s[SW-1:0];
    return s[PW-1] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
  endfunction
endpackage

// File: rtl/ilv_core_sel.sv
module ilv_core_sel #(
  parameter int NCORE = 4,
  localparam int IW = $clog2(NCORE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= (idx == IW'(NCORE - 1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/ilv_estimator.sv
module ilv_estimator
  import ilv_cal_pkg::*;
#(
  parameter int NCORE = 4,
  localparam int IW = $clog2(NCORE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [IW-1:0]     idx,
  input  samp_t             x,
  input  logic [KW-1:0]     k_raw,
  output samp_t             off_cur,
  output gain_t             g_cur,
  output logic [NCORE*SW-1:0] off_vec,
  output logic [NCORE*GW-1:0] gain_vec
);
  acc_t  acc_off [NCORE];
  acc_t  acc_mag [NCORE];
  gain_t g_r     [NCORE];
  logic [SW-1:0] mag_int [NCORE];
  logic [SW+IW-1:0] msum;
  logic [SW-1:0] avg;
  logic [KW-1:0] k_eff;
  logic signed [SW:0] d, absd;

  genvar gc;
  generate
    for (gc = 0; gc < NCORE; gc++) begin : g_core
      assign mag_int[gc] = acc_mag[gc][FR+SW-1:FR];
      assign off_vec[gc*SW +: SW]  = acc_off[gc][FR+SW-1:FR];
      assign gain_vec[gc*GW +: GW] = g_r[gc];
    end
  endgenerate

  always_comb begin
    msum = '0;
    for (int c = 0; c < NCORE; c++) msum = msum + (SW+IW)'(mag_int[c]);
    avg = msum[SW+IW-1:IW];
  end

  assign k_eff   = clamp_k(k_raw);
  assign off_cur = acc_off[idx][FR+SW-1:FR];
  assign g_cur   = g_r[idx];
  assign d       = {x[SW-1], x} - {off_cur[SW-1], off_cur};
  assign absd    = d[SW] ? -d : d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCORE; c++) begin
        acc_off[c] <= '0;
        acc_mag[c] <= '0;
        g_r[c]     <= GAIN_ONE;
      end
    end else if (upd) begin
      acc_off[idx] <= leaky_step(acc_off[idx], {x[SW-1], x}, k_eff);
      acc_mag[idx] <= leaky_step(acc_mag[idx], absd, k_eff);
      g_r[idx]     <= gain_step(g_r[idx], mag_int[idx], avg);
    end
  end
endmodule

// File: rtl/ilv_corr_pipe.sv
module ilv_corr_pipe
  import ilv_cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_i,
  input  logic  en_i,
  input  samp_t x_i,
  input  samp_t off_i,
  input  gain_t g_i,
  output logic  vld_o,
  output samp_t y_o
);
  logic               s1_vld, s1_en, s2_vld, s2_en;
  samp_t              s1_x, s2_x;
  logic signed [SW:0] s1_d;
  gain_t              s1_g;
  logic signed [PW-1:0] s2_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_en <= 1'b0; s1_x <= '0; s1_d <= '0; s1_g <= '0;
      s2_vld <= 1'b0; s2_en <= 1'b0; s2_x <= '0; s2_p <= '0;
      vld_o  <= 1'b0; y_o   <= '0;
    end else begin
      s1_vld <= vld_i;
      s1_en  <= en_i;
      s1_x   <= x_i;
      s1_d   <= {x_i[SW-1], x_i} - {off_i[SW-1], off_i};
      s1_g   <= g_i;
      s2_vld <= s1_vld;
      s2_en  <= s1_en;
      s2_x   <= s1_x;
      s2_p   <= s1_d * $signed({1'b0, s1_g});
      vld_o  <= s2_vld;
      y_o    <= s2_en ? shift_sat(s2_p) : s2_x;
    end
  end
endmodule

// File: rtl/ilv_mismatch_cal.sv
module ilv_mismatch_cal
  import ilv_cal_pkg::*;
#(
  parameter int NCORE = 4,
  localparam int IW = $clog2(NCORE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          freeze,
  input  logic [4:0]    k_shift,
  input  logic          in_vld,
  input  logic [15:0]   in_dat,
  output logic          out_vld,
  output logic [15:0]   out_dat,
  input  logic [IW-1:0] rd_core,
  output logic [15:0]   rd_offset,
  output logic [15:0]   rd_gain
);
  logic [IW-1:0]       core_idx;
  logic                est_upd;
  samp_t               off_cur, y;
  gain_t               g_cur;
  logic [NCORE*SW-1:0] off_vec;
  logic [NCORE*GW-1:0] gain_vec;

  assign est_upd = in_vld & en & ~freeze;

  ilv_core_sel #(.NCORE(NCORE)) u_sel (
    .clk(clk), .rst_n(rst_n), .step(in_vld), .idx(core_idx)
  );

  ilv_estimator #(.NCORE(NCORE)) u_est (
    .clk(clk), .rst_n(rst_n), .upd(est_upd), .idx(core_idx), .x(samp_t'(in_dat)),
    .k_raw(k_shift), .off_cur(off_cur), .g_cur(g_cur),
    .off_vec(off_vec), .gain_vec(gain_vec)
  );

  ilv_corr_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .vld_i(in_vld), .en_i(en), .x_i(samp_t'(in_dat)),
    .off_i(off_cur), .g_i(g_cur), .vld_o(out_vld), .y_o(y)
  );

  assign out_dat   = y;
  assign rd_offset = off_vec[rd_core*SW +: SW];
  assign rd_gain   = gain_vec[rd_core*GW +: GW];
endmodule

// File: rtl/ilv_cal_chk.sv
module ilv_cal_chk #(
  parameter int NCORE = 4,
  parameter int SW = 16,
  localparam int IW = $clog2(NCORE)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                freeze,
  input logic                in_vld,
  input logic [SW-1:0]       in_dat,
  input logic                out_vld,
  input logic [SW-1:0]       out_dat,
  input logic [IW-1:0]       core_idx,
  input logic [NCORE*SW-1:0] off_vec,
  input logic [NCORE*SW-1:0] gain_vec
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end

  assert_core_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> core_idx == IW'($past(core_idx) + 1'b1));
  assert_core_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(core_idx));
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> out_vld == $past(in_vld, 3));
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_vld && !$past(en, 3)) |-> out_dat == $past(in_dat, 3));
  assert_hold_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze || !en || !in_vld) |=> ($stable(off_vec) && $stable(gain_vec)));

  genvar gc;
  generate
    for (gc = 0; gc < NCORE; gc++) begin : g_chk
      assert_other_core_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_idx != IW'(gc)) |=> $stable(off_vec[gc*SW +: SW]));
      assert_gain_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_vec[gc*SW +: SW] == $past(gain_vec[gc*SW +: SW])) ||
        (gain_vec[gc*SW +: SW] == SW'($past(gain_vec[gc*SW +: SW]) + 1'b1)) ||
        (gain_vec[gc*SW +: SW] == SW'($past(gain_vec[gc*SW +: SW]) - 1'b1)));
    end
  endgenerate
endmodule

bind ilv_mismatch_cal ilv_cal_chk #(.NCORE(NCORE), .SW(16)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .freeze(freeze), .in_vld(in_vld),
  .in_dat(in_dat), .out_vld(out_vld), .out_dat(out_dat), .core_idx(core_idx),
  .off_vec(off_vec), .gain_vec(gain_vec)
);

// File: tb/test_ilv_mismatch_cal.sv
module test_ilv_mismatch_cal;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en, freeze, in_vld, out_vld;
  logic [4:0] k_shift;
  logic [15:0] in_dat, out_dat, rd_offset, rd_gain;
  logic [1:0] rd_core;

  ilv_mismatch_cal i_ilv_mismatch_cal (
    .clk(clk), .rst_n(rst_n), .en(en), .freeze(freeze), .k_shift(k_shift),
    .in_vld(in_vld), .in_dat(in_dat), .out_vld(out_vld), .out_dat(out_dat),
    .rd_core(rd_core), .rd_offset(rd_offset), .rd_gain(rd_gain)
  );

  int total = 0, bad = 0, sat_hits = 0;
  longint acc_m [4], mag_m [4], g_m [4];
  int idx_m = 0;
  bit    sh_v [3];
  int    sh_y [3];
  string sh_r [3];
  int    bias [4] = '{1200, -900, 300, -2500};
  int    scl  [4] = '{16, 18, 14, 17};

  function automatic longint sat16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int kclamp(input int k);
    return (k < 8) ? 8 : ((k > 16) ? 16 : k);
  endfunction

  task automatic report(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: check the output due now, then apply the next input
  task automatic step(input bit v, input int x, input bit e, input bit f, input int k);
    longint off, y, d, ad, avg, lhs;
    longint mi [4];
    int i;
    string r;
    @(negedge clk);
    if (sh_v[2] || out_vld) begin
      report(out_vld == sh_v[2], "R2 out_vld", out_vld, sh_v[2]);
      if (sh_v[2])
        report(longint'($signed(out_dat)) == sh_y[2], sh_r[2], $signed(out_dat), sh_y[2]);
    end
    sh_v[2] = sh_v[1]; sh_y[2] = sh_y[1]; sh_r[2] = sh_r[1];
    sh_v[1] = sh_v[0]; sh_y[1] = sh_y[0]; sh_r[1] = sh_r[0];
    sh_v[0] = v; sh_y[0] = 0; sh_r[0] = "";
    if (v) begin
      i = idx_m;
      off = acc_m[i] >>> 16;
      if (e) begin
        y = sat16(((longint'(x) - off) * g_m[i]) >>> 14);
        r = f ? "R8 data" : "R3 data";
        if (y != (((longint'(x) - off) * g_m[i]) >>> 14)) begin
          r = "R4 sat"; sat_hits++;
        end
      end else begin
        y = x; r = "R9 bypass";
      end
      sh_y[0] = int'(y); sh_r[0] = r;
      if (e && !f) begin
        for (int c = 0; c < 4; c++) mi[c] = mag_m[c] >>> 16;
        avg = (mi[0] + mi[1] + mi[2] + mi[3]) >>> 2;
        d  = longint'(x) - off;
        ad = (d < 0) ? -d : d;
        acc_m[i] = acc_m[i] + (((longint'(x) <<< 16) - acc_m[i]) >>> kclamp(k));
        mag_m[i] = mag_m[i] + (((ad <<< 16) - mag_m[i]) >>> kclamp(k));
        lhs = g_m[i] * mi[i];
        if (lhs < (avg <<< 14) && g_m[i] < 65535) g_m[i]++;
        else if (lhs > (avg <<< 14) && g_m[i] > 0) g_m[i]--;
      end
      idx_m = (idx_m + 1) % 4;
    end
    in_vld = v; in_dat = 16'(x); en = e; freeze = f; k_shift = 5'(k);
  endtask

  task automatic readback(input string tag);
    step(1'b0, 0, en, freeze, int'(k_shift));
    for (int c = 0; c < 4; c++) begin
      rd_core = 2'(c);
      #1;
      report(longint'($signed(rd_offset)) == (acc_m[c] >>> 16), {tag, " offset"},
             $signed(rd_offset), acc_m[c] >>> 16);
      report(longint'(rd_gain) == g_m[c], {tag, " gain"}, rd_gain, g_m[c]);
    end
  endtask

  function automatic int shaped(input int c);
    int r;
    r = int'($urandom_range(16000)) - 8000;
    return bias[c] + ((r * scl[c]) >>> 4);
  endfunction

  task automatic burst(input int n, input bit e, input bit f, input int k, input int gap_pct);
    for (int j = 0; j < n; j++) begin
      if (int'($urandom_range(99)) < gap_pct) step(1'b0, 0, e, f, k);
      else step(1'b1, shaped(idx_m), e, f, k);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int c = 0; c < 4; c++) begin acc_m[c] = 0; mag_m[c] = 0; g_m[c] = 16384; end
    for (int s = 0; s < 3; s++) begin sh_v[s] = 0; sh_y[s] = 0; sh_r[s] = ""; end
    rst_n = 1'b0; en = 1'b0; freeze = 1'b0; in_vld = 1'b0; in_dat = '0;
    k_shift = 5'd8; rd_core = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    report(out_vld == 1'b0, "R2 reset out_vld", out_vld, 0);
    readback("R10 reset");

    // bypass: data unchanged, estimates untouched
    burst(40, 1'b0, 1'b0, 8, 20);
    readback("R9 after bypass");

    // background training with per-core bias and amplitude, gaps in the stream
    burst(3000, 1'b1, 1'b0, 8, 20);
    readback("R1 R5 R6 after training");

    // leak shift clamp below and above the range
    burst(300, 1'b1, 1'b0, 3, 10);
    readback("R7 low clamp");
    burst(300, 1'b1, 1'b0, 25, 10);
    readback("R7 high clamp");

    // freeze: corrections applied, estimates held
    burst(300, 1'b1, 1'b1, 8, 10);
    readback("R8 frozen");

    // saturation: drive large opposite offsets into cores 0 and 1
    for (int j = 0; j < 2400; j++) begin
      case (idx_m)
        0: step(1'b1, 30000, 1'b1, 1'b0, 8);
        1: step(1'b1, -30000, 1'b1, 1'b0, 8);
        default: step(1'b1, shaped(idx_m), 1'b1, 1'b0, 8);
      endcase
    end
    for (int j = 0; j < 16; j++) begin
      case (idx_m)
        0: step(1'b1, -32768, 1'b1, 1'b1, 8);
        1: step(1'b1, 32767, 1'b1, 1'b1, 8);
        default: step(1'b1, 0, 1'b1, 1'b1, 8);
      endcase
    end
    readback("R4 R5 after saturation run");
    report(sat_hits > 0, "R4 saturation reached", sat_hits, 1);

    // mixed random control
    for (int j = 0; j < 40; j++)
      burst(25, 1'($urandom_range(1)), 1'($urandom_range(1)), int'($urandom_range(20)), 15);
    readback("R3 R8 R9 mixed");

    repeat (4) step(1'b0, 0, 1'b1, 1'b0, 8);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule